// File: doc/BRIEF.md
# Paged DMA Address Translation Unit

This block maps addresses issued by a DMA-capable device onto system physical addresses. A window is defined by a base offset, a page shift and an entry count. Each page of the window has one 64-bit translation entry. The page-aligned part of an entry is the physical page address. Its two lowest bits hold the access right for that page.

A lookup is presented with a one-cycle request strobe. One cycle later the block returns:
- the page-aligned window-relative address;
- the translated page address;
- the page-offset mask;
- the permission.

An address outside the window never raises an error. It returns a "no access" answer whose mask is all ones.

The entries are kept in an internal register array. A separate update port writes the entries, and a clear input wipes them. Enable and disable requests set up and tear down the window geometry.

Top module: `dma_xlate`

## Requirements
- R1: `rsp_perm` carries bits [1:0] of the selected entry on an in-window lookup, encoded as 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R2: A lookup address is inside the window only when both conditions hold: it is at or above the base offset, and (address - base) >> shift is less than the entry count.
- R3: For an in-window lookup, the selected entry is the one with index (address - base) >> shift. The outputs are `rsp_mask` = 2^shift - 1, `rsp_iova` = (address - base) with the mask bits cleared, and `rsp_xlat` = entry with the mask bits cleared.
- R4: For a lookup outside the window, the outputs are `rsp_perm` = 0, `rsp_iova` = 0, `rsp_xlat` = 0 and `rsp_mask` = all ones.
- R5: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. Back-to-back requests each get their own answer, and `rsp_valid` is low in every other cycle.
- R6: After `rst_n` the block is in this state:
  - the shift is 12, the base is 0 and the count is 0, so every lookup is outside the window;
  - `warn_o` and `rsp_valid` are low.
- R7: An enable request made while the count is zero does two things:
  - it loads the shift, the base and the count, with the count limited to DEPTH;
  - it zeroes every entry.
- R8: An enable request made while the count is nonzero has no effect on the geometry or the entries. `warn_o` is high for the one cycle that follows it.
- R9: A disable request sets the base, the shift and the count to zero, so later lookups fall outside the window. When enable and disable are requested in the same cycle, disable wins.
- R10: `clr_i` zeroes every entry and keeps the geometry. It wins over an update in the same cycle.
- R11: An update writes `upd_data` into entry `upd_idx` at the clock edge. A lookup in the same cycle returns the value the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Enable the window with the cfg_* values |
| dis_req | input | 1 | Disable the window |
| cfg_shift | input | SH_W | Page shift to load on enable |
| cfg_base | input | DATA_W | Window base offset to load on enable |
| cfg_count | input | CNT_W | Entry count to load on enable |
| clr_i | input | 1 | Zero all entries |
| upd_we | input | 1 | Entry write strobe |
| upd_idx | input | IDX_W | Entry index to write |
| upd_data | input | DATA_W | Entry value to write |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | DATA_W | Device address to translate |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_perm | output | 2 | Access right |
| rsp_iova | output | DATA_W | Page-aligned window-relative address |
| rsp_xlat | output | DATA_W | Translated page address |
| rsp_mask | output | DATA_W | Page-offset mask |
| warn_o | output | 1 | Enable was requested while already enabled |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 64. The count input is then four bits wide, so a request for twelve entries can be made and the clamp to eight becomes observable. Page shifts of 12 and 16 are both exercised, so the mask, the IOVA alignment and the entry selection are seen at two granularities. With a base well above zero, the address just below the base and the address one page past the last entry both come within reach.

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int DEF_SHIFT = 12,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic [SH_W-1:0]   cfg_shift,
  input  logic [DATA_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              clr_i,
  input  logic              upd_we,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_perm,
  output logic [DATA_W-1:0] rsp_iova,
  output logic [DATA_W-1:0] rsp_xlat,
  output logic [DATA_W-1:0] rsp_mask,
  output logic              warn_o
);

  logic [SH_W-1:0]   shift_r;
  logic [DATA_W-1:0] base_r;
  logic [CNT_W-1:0]  count_r;
  logic [DATA_W-1:0] tbl [DEPTH];

  wire load   = en_req && !dis_req && (count_r == '0);
  wire reject = en_req && !dis_req && (count_r != '0);
  wire [CNT_W-1:0] cnt_lim = (cfg_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_r <= SH_W'(DEF_SHIFT);
      base_r  <= '0;
      count_r <= '0;
      warn_o  <= 1'b0;
    end else begin
      warn_o <= reject;
      if (dis_req) begin
        shift_r <= '0;
        base_r  <= '0;
        count_r <= '0;
      end else if (load) begin
        shift_r <= cfg_shift;
        base_r  <= cfg_base;
        count_r <= cnt_lim;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (clr_i || load) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (upd_we) begin
      tbl[upd_idx] <= upd_data;
    end
  end

  wire [DATA_W-1:0] rel  = req_addr - base_r;
  wire [DATA_W-1:0] pidx = rel >> shift_r;
  wire [DATA_W-1:0] mask = (DATA_W'(1) << shift_r) - DATA_W'(1);
  wire              hit  = (req_addr >= base_r) && (pidx < DATA_W'(count_r));
  wire [DATA_W-1:0] ent  = tbl[pidx[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_perm  <= 2'd0;
      rsp_iova  <= '0;
      rsp_xlat  <= '0;
      rsp_mask  <= '1;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_perm <= hit ? ent[1:0] : 2'd0;
        rsp_iova <= hit ? (rel & ~mask) : '0;
        rsp_xlat <= hit ? (ent & ~mask) : '0;
        rsp_mask <= hit ? mask : '1;
      end
    end
  end

  p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_oob_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (&rsp_mask)) |-> (rsp_perm == 2'd0 && rsp_iova == '0 && rsp_xlat == '0));
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(&rsp_mask)) |-> ((rsp_iova & rsp_mask) == '0 && (rsp_xlat & rsp_mask) == '0));
  p_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |-> $past(en_req));
  p_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> (count_r == '0 && base_r == '0 && shift_r == '0));
  p_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_r <= CNT_W'(DEPTH));

endmodule

// File: tb/dma_xlate_test.sv
module dma_xlate_test;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 8;
  localparam int SH_W   = 6;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 4;
  localparam logic [63:0] B = 64'h1000_0000;
  localparam logic [63:0] ALL1 = '1;

  logic clk = 0, rst_n = 0;
  logic en_req = 0, dis_req = 0, clr_i = 0, upd_we = 0, req_valid = 0;
  logic [SH_W-1:0] cfg_shift = 0;
  logic [63:0] cfg_base = 0, upd_data = 0, req_addr = 0;
  logic [CNT_W-1:0] cfg_count = 0;
  logic [IDX_W-1:0] upd_idx = 0;
  logic rsp_valid, warn_o;
  logic [1:0] rsp_perm;
  logic [63:0] rsp_iova, rsp_xlat, rsp_mask;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dma_xlate #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .cfg_shift(cfg_shift), .cfg_base(cfg_base), .cfg_count(cfg_count),
    .clr_i(clr_i), .upd_we(upd_we), .upd_idx(upd_idx), .upd_data(upd_data),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_perm(rsp_perm), .rsp_iova(rsp_iova), .rsp_xlat(rsp_xlat),
    .rsp_mask(rsp_mask), .warn_o(warn_o));

  function automatic logic [63:0] ent(int i);
    return 64'h80_0000_0000 + (64'(i) << 16) + 64'h5A0 + 64'(i % 4);
  endfunction

  localparam logic [63:0] V_ADDR [7] = '{B + 64'h0123, B + 64'h1FFF, B + 64'h7ABC,
                                         B + 64'h8000, B - 64'h1, 64'h0, B + 64'h3000};
  localparam int V_IDX [7] = '{0, 1, 7, -1, -1, -1, 3};

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg(logic e, logic d, logic [SH_W-1:0] s, logic [63:0] b, logic [CNT_W-1:0] c);
    @(negedge clk);
    en_req = e; dis_req = d; cfg_shift = s; cfg_base = b; cfg_count = c;
    @(negedge clk);
    en_req = 0; dis_req = 0;
  endtask

  task automatic wr(int i, logic [63:0] v);
    @(negedge clk);
    upd_we = 1; upd_idx = IDX_W'(i); upd_data = v;
    @(negedge clk);
    upd_we = 0;
  endtask

  task automatic look(logic [63:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic exp_hit(string tag, logic [63:0] iova, logic [63:0] xl, logic [1:0] p, logic [63:0] m);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " perm"}, 64'(rsp_perm), 64'(p));
    chk({tag, " iova"}, rsp_iova, iova);
    chk({tag, " xlat"}, rsp_xlat, xl);
    chk({tag, " mask"}, rsp_mask, m);
  endtask

  task automatic exp_oob(string tag);
    exp_hit(tag, 64'h0, 64'h0, 2'd0, ALL1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6 reset state
    chk("R6 rsp_valid", 64'(rsp_valid), 0);
    chk("R6 warn_o", 64'(warn_o), 0);
    look(64'h0);
    exp_oob("R6 lookup after reset");

    // R7 enable and fill table
    cfg(1, 0, 6'd12, B, 4'd8);
    chk("R7 no warn", 64'(warn_o), 0);
    for (int i = 0; i < 8; i++) wr(i, ent(i));

    // R1 R2 R3 R4 vector walk
    for (int k = 0; k < 7; k++) begin
      look(V_ADDR[k]);
      if (V_IDX[k] < 0) exp_oob($sformatf("R2 R4 vec%0d", k));
      else exp_hit($sformatf("R1 R3 vec%0d", k), (V_ADDR[k] - B) & ~64'hFFF,
                   ent(V_IDX[k]) & ~64'hFFF, 2'(V_IDX[k] % 4), 64'hFFF);
    end

    // R8 second enable ignored, warn pulse
    cfg(1, 0, 6'd16, 64'h0, 4'd2);
    chk("R8 warn high", 64'(warn_o), 1);
    @(negedge clk);
    chk("R8 warn drops", 64'(warn_o), 0);
    look(B + 64'h5000);
    exp_hit("R8 geometry kept", 64'h5000, ent(5) & ~64'hFFF, 2'd1, 64'hFFF);

    // R5 back to back, then idle
    @(negedge clk);
    req_valid = 1; req_addr = B + 64'h2010;
    @(negedge clk);
    req_addr = B + 64'h9000;
    exp_hit("R5 first", 64'h2000, ent(2) & ~64'hFFF, 2'd2, 64'hFFF);
    @(negedge clk);
    req_valid = 0;
    exp_oob("R5 second");
    @(negedge clk);
    chk("R5 idle", 64'(rsp_valid), 0);

    // R11 same-cycle lookup and update
    @(negedge clk);
    req_valid = 1; req_addr = B + 64'h4444;
    upd_we = 1; upd_idx = 3'd4; upd_data = 64'hDEAD_B000_0003;
    @(negedge clk);
    req_valid = 0; upd_we = 0;
    exp_hit("R11 old value", 64'h4000, ent(4) & ~64'hFFF, 2'd0, 64'hFFF);
    look(B + 64'h4444);
    exp_hit("R11 new value", 64'h4000, 64'hDEAD_B000_0000, 2'd3, 64'hFFF);

    // R10 clear with same-cycle update
    @(negedge clk);
    clr_i = 1; upd_we = 1; upd_idx = 3'd1; upd_data = 64'h1234_5003;
    @(negedge clk);
    clr_i = 0; upd_we = 0;
    look(B + 64'h1000);
    exp_hit("R10 cleared entry", 64'h1000, 64'h0, 2'd0, 64'hFFF);
    look(B + 64'h7000);
    exp_hit("R10 geometry kept", 64'h7000, 64'h0, 2'd0, 64'hFFF);

    // R9 disable
    cfg(0, 1, 0, 0, 0);
    look(B + 64'h1000);
    exp_oob("R9 disabled");

    // R7 new geometry, entries zeroed, shift 16
    wr(2, 64'h77_0003_2345);
    cfg(1, 0, 6'd16, 64'h0, 4'd3);
    look(64'h2_1234);
    exp_hit("R7 zeroed on enable", 64'h2_0000, 64'h0, 2'd0, 64'hFFFF);
    wr(2, 64'h77_0003_2345);
    look(64'h2_1234);
    exp_hit("R3 shift16", 64'h2_0000, 64'h77_0003_0000, 2'd1, 64'hFFFF);
    look(64'h3_0000);
    exp_oob("R2 past count");

    // R9 enable and disable together
    cfg(1, 1, 6'd12, B, 4'd4);
    look(B);
    exp_oob("R9 disable wins");
    chk("R9 no warn", 64'(warn_o), 0);

    // R7 count clamp
    cfg(1, 0, 6'd12, 64'h0, 4'd12);
    wr(7, 64'h9000_0001);
    look(64'h7FFF);
    exp_hit("R7 clamp last entry", 64'h7000, 64'h9000_0000, 2'd1, 64'hFFF);
    look(64'h8000);
    exp_oob("R7 clamp beyond");

    finish_run();
  end
endmodule